// File: doc/BRIEF.md
# XGMII to XAUI Transmit Character Mapper

This block sits on the transmit side of a four-lane 10-gigabit attachment, between the XGMII-side parallel input and the per-lane 8b/10b encoders. Each clock it takes one column: one byte and one control flag per lane. It returns the byte that each lane's encoder should encode, a flag that says whether that byte is a special (K) character, and a flag that marks an invalid input code. Lane 0 of the input column is lane 0 of the output and feeds the first channel.

Ordinary data passes through unchanged. Control bytes are resolved against a small set of fixed codes and against an idle code held in a writable register. The mapper works in one of two idle styles. In the fixed style every idle-class control character maps one to one onto a special character. In the randomized style a column made entirely of idle-class characters is replaced by a pseudo-random idle stream. That stream is built from a comma column, a skip column and an alignment column, with the alignment column repeated at a pseudo-random interval.

Top module: `xgx_char_mapper`

## Requirements
- R1: While rst_n is low, tx_char, tx_kflag and tx_invalid are all zero. The idle-code register resets to 0x07. Every output reflects the column presented one clock earlier.
- R2: A lane whose control flag is 0 outputs its input byte with tx_kflag 0 and tx_invalid 0.
- R3: A control byte 0xFB outputs 0xFB (start, K27.7) with tx_kflag 1, in every configuration and every column.
- R4: Outside randomized mode, these control bytes map as follows. Each output has tx_kflag 1.
  - The idle code (with cfg_trans_en 1) gives 0xBC (K28.5).
  - 0xBC gives 0xBC.
  - 0x7C gives 0x7C (K28.3).
  - 0x1C gives 0x1C (K28.0).
- R5: When a control byte equals the idle code and cfg_trans_en is 0, the lane outputs 0xFE with tx_kflag 1 and tx_invalid 1. tx_invalid is 0 in every other case.
- R6: Any other control byte is passed through unchanged with tx_kflag 1.
- R7: A write through idle_wr replaces the idle code from the next column onwards. A write of 0xBC, 0x7C, 0x1C or 0xFB is ignored and the old code stays in force.
- R8: Randomized mode is on exactly when cfg_xaui_en is 1, or when cfg_trans_en and cfg_akr_en are both 1.
- R9: In randomized mode, a column is idle when every lane holds an idle-class control. Idle-class means 0xBC, 0x7C, 0x1C, or the idle code while cfg_trans_en is 1. An idle column is replaced in all lanes by one common sequencer symbol: 0xBC, 0x7C or 0x1C, with tx_kflag 1. An idle-class lane in any other column uses the mapping of R4.
- R10: The first idle column after a non-idle column, and the first idle column after reset, is 0xBC in all lanes.
- R11: An alignment column (0x7C) is emitted when the interval counter has reached zero. The counter resets to 0. After each alignment column it reloads with 15 plus the low four bits of the sequencer state, and it counts down by one every column. Successive alignment columns are therefore 16 to 31 columns apart, or further if non-idle columns intervene.
- R12: The sequencer state is a 7-bit register with feedback x^7 + x^6 + 1. Each column it shifts left, and the XOR of bits 6 and 5 enters bit 0. It resets to 0x7F and advances every column. When an idle column is neither first (R10) nor an alignment column, it is 0x1C if state bit 6 is 1 and 0xBC otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trans_en | input | 1 | Idle code is recognized as idle when 1, invalid when 0 |
| cfg_akr_en | input | 1 | With cfg_trans_en, selects randomized idle |
| cfg_xaui_en | input | 1 | Selects randomized idle on its own |
| idle_wr | input | 1 | Write strobe for the idle-code register |
| idle_wr_data | input | 8 | Value written to the idle-code register |
| xg_data | input | 32 | Input column; byte n is lane n |
| xg_ctl | input | 4 | Per-lane control flag of the input column |
| tx_char | output | 32 | Output column to the encoders; byte n is lane n |
| tx_kflag | output | 4 | Per-lane special-character flag |
| tx_invalid | output | 4 | Per-lane invalid-code flag |

## Verification
The bench aims at the enable combinations that differ by one bit: trans-enable without AKR-enable, and AKR-enable without trans-enable. A design that decodes the randomized-mode condition wrongly would send a pseudo-random stream where a fixed comma belongs, or the reverse. It writes a reserved value to the idle register, which a design lacking the write filter would turn into a shadowed or doubled decode. It mixes idle columns with columns that hold one data lane, so a design that sequenced lane by lane instead of column by column would desynchronize the lanes. Long idle runs follow the alignment interval and the comma/skip choice against an independent model of the polynomial. An off-by-one in the reload, or a tap on the wrong bit, shows up as an alignment column one column early or late.

// File: rtl/xgx_map_pkg.sv
package xgx_map_pkg;

   localparam logic [7:0] CH_COMMA = 8'hBC;   // K28.5
   localparam logic [7:0] CH_ALIGN = 8'h7C;   // K28.3
   localparam logic [7:0] CH_SKIP  = 8'h1C;   // K28.0
   localparam logic [7:0] CH_START = 8'hFB;   // K27.7
   localparam logic [7:0] CH_BAD   = 8'hFE;   // error character

   typedef enum logic [2:0] {
      CLS_DATA,
      CLS_IDLE,
      CLS_COMMA,
      CLS_ALIGN,
      CLS_SKIP,
      CLS_START,
      CLS_OTHER,
      CLS_BAD
   } lane_cls_e;

   typedef enum logic [1:0] {
      SYM_K,
      SYM_A,
      SYM_R
   } seq_sym_e;

   function automatic logic is_fixed_ctl(input logic [7:0] b);
      return (b == CH_COMMA) || (b == CH_ALIGN) || (b == CH_SKIP) || (b == CH_START);
   endfunction

   function automatic logic is_idle_class(input lane_cls_e c);
      return (c == CLS_IDLE) || (c == CLS_COMMA) || (c == CLS_ALIGN) || (c == CLS_SKIP);
   endfunction

   function automatic logic [7:0] sym_char(input seq_sym_e s);
      case (s)
         SYM_A:   return CH_ALIGN;
         SYM_R:   return CH_SKIP;
         default: return CH_COMMA;
      endcase
   endfunction

endpackage

// File: rtl/xgx_idle_code_reg.sv
module xgx_idle_code_reg
   import xgx_map_pkg::*;
#(
   parameter int          BYTE_W  = 8,
   parameter logic [7:0]  RST_VAL = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] code
);

   logic accept;

   always_comb accept = wr_en && !is_fixed_ctl(wr_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code <= RST_VAL;
      else if (accept) code <= wr_data;
   end

endmodule

// File: rtl/xgx_lane_classify.sv
module xgx_lane_classify
   import xgx_map_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] data,
   input  logic              ctl,
   input  logic [BYTE_W-1:0] idle_code,
   input  logic              trans_en,
   output lane_cls_e         cls
);

   always_comb begin
      if (!ctl)                    cls = CLS_DATA;
      else if (data == CH_START)   cls = CLS_START;
      else if (data == CH_COMMA)   cls = CLS_COMMA;
      else if (data == CH_ALIGN)   cls = CLS_ALIGN;
      else if (data == CH_SKIP)    cls = CLS_SKIP;
      else if (data == idle_code)  cls = trans_en ? CLS_IDLE : CLS_BAD;
      else                         cls = CLS_OTHER;
   end

endmodule

// File: rtl/xgx_akr_seq.sv
module xgx_akr_seq
   import xgx_map_pkg::*;
#(
   parameter int             PRBS_W      = 7,
   parameter int             TAP_HI      = 6,
   parameter int             TAP_LO      = 5,
   parameter logic [PRBS_W-1:0] SEED     = 7'h7F,
   parameter int             A_MIN       = 16,
   parameter int             A_SPAN_BITS = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     col_idle,
   output seq_sym_e sym
);

   localparam int CNT_MAX = A_MIN - 1 + (1 << A_SPAN_BITS) - 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [PRBS_W-1:0] prbs_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              prev_idle_q;
   logic [CNT_W-1:0]  reload;

   always_comb begin
      reload = CNT_W'(A_MIN - 1) + CNT_W'(prbs_q[A_SPAN_BITS-1:0]);
      if (!prev_idle_q)         sym = SYM_K;
      else if (cnt_q == '0)     sym = SYM_A;
      else if (prbs_q[PRBS_W-1]) sym = SYM_R;
      else                      sym = SYM_K;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prbs_q      <= SEED;
         cnt_q       <= '0;
         prev_idle_q <= 1'b0;
      end else begin
         prbs_q      <= {prbs_q[PRBS_W-2:0], prbs_q[TAP_HI] ^ prbs_q[TAP_LO]};
         prev_idle_q <= col_idle;
         if (col_idle && sym == SYM_A) cnt_q <= reload;
         else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/xgx_lane_emit.sv
module xgx_lane_emit
   import xgx_map_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  lane_cls_e         cls,
   input  logic [BYTE_W-1:0] data,
   input  logic              col_idle,
   input  seq_sym_e          sym,
   output logic [BYTE_W-1:0] ch,
   output logic              kf,
   output logic              bad
);

   always_comb begin
      ch  = data;
      kf  = 1'b1;
      bad = 1'b0;
      if (col_idle && is_idle_class(cls)) begin
         ch = sym_char(sym);
      end else begin
         case (cls)
            CLS_DATA:  kf = 1'b0;
            CLS_START: ch = CH_START;
            CLS_IDLE,
            CLS_COMMA: ch = CH_COMMA;
            CLS_ALIGN: ch = CH_ALIGN;
            CLS_SKIP:  ch = CH_SKIP;
            CLS_BAD: begin
               ch  = CH_BAD;
               bad = 1'b1;
            end
            default:   ch = data;
         endcase
      end
   end

endmodule

// File: rtl/xgx_char_mapper.sv
module xgx_char_mapper
   import xgx_map_pkg::*;
#(
   parameter int             LANES       = 4,
   parameter int             BYTE_W      = 8,
   parameter logic [7:0]     IDLE_RST    = 8'h07,
   parameter int             PRBS_W      = 7,
   parameter logic [6:0]     PRBS_SEED   = 7'h7F,
   parameter int             A_MIN       = 16,
   parameter int             A_SPAN_BITS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_trans_en,
   input  logic                    cfg_akr_en,
   input  logic                    cfg_xaui_en,
   input  logic                    idle_wr,
   input  logic [BYTE_W-1:0]       idle_wr_data,
   input  logic [LANES*BYTE_W-1:0] xg_data,
   input  logic [LANES-1:0]        xg_ctl,
   output logic [LANES*BYTE_W-1:0] tx_char,
   output logic [LANES-1:0]        tx_kflag,
   output logic [LANES-1:0]        tx_invalid
);

   localparam int COL_W = LANES * BYTE_W;

   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end
   if (BYTE_W != 8) begin : g_chk_byte
      $error("BYTE_W must be 8");
   end
   if (PRBS_W != 7) begin : g_chk_prbs
      $error("PRBS_W must be 7 for x^7 + x^6 + 1");
   end
   if (A_SPAN_BITS < 1 || A_SPAN_BITS >= PRBS_W) begin : g_chk_span
      $error("A_SPAN_BITS out of range");
   end
   if (A_MIN < 2) begin : g_chk_amin
      $error("A_MIN must be at least 2");
   end
   if (PRBS_SEED == '0) begin : g_chk_seed
      $error("PRBS_SEED must be nonzero");
   end

   logic [BYTE_W-1:0] idle_code;
   logic              rand_mode;
   logic              col_idle;
   seq_sym_e          sym;
   lane_cls_e         cls   [LANES];
   logic [LANES-1:0]  idle_cls;
   logic [COL_W-1:0]  nxt_char;
   logic [LANES-1:0]  nxt_k;
   logic [LANES-1:0]  nxt_bad;

   xgx_idle_code_reg #(
      .BYTE_W  (BYTE_W),
      .RST_VAL (IDLE_RST)
   ) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (idle_wr),
      .wr_data (idle_wr_data),
      .code    (idle_code)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xgx_lane_classify #(.BYTE_W(BYTE_W)) u_cls (
         .data      (xg_data[i*BYTE_W +: BYTE_W]),
         .ctl       (xg_ctl[i]),
         .idle_code (idle_code),
         .trans_en  (cfg_trans_en),
         .cls       (cls[i])
      );
      assign idle_cls[i] = is_idle_class(cls[i]);
      xgx_lane_emit #(.BYTE_W(BYTE_W)) u_emit (
         .cls      (cls[i]),
         .data     (xg_data[i*BYTE_W +: BYTE_W]),
         .col_idle (col_idle),
         .sym      (sym),
         .ch       (nxt_char[i*BYTE_W +: BYTE_W]),
         .kf       (nxt_k[i]),
         .bad      (nxt_bad[i])
      );
   end

   always_comb begin
      rand_mode = cfg_xaui_en || (cfg_trans_en && cfg_akr_en);
      col_idle  = rand_mode && (&idle_cls);
   end

   xgx_akr_seq #(
      .PRBS_W      (PRBS_W),
      .TAP_HI      (PRBS_W - 1),
      .TAP_LO      (PRBS_W - 2),
      .SEED        (PRBS_SEED),
      .A_MIN       (A_MIN),
      .A_SPAN_BITS (A_SPAN_BITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .col_idle (col_idle),
      .sym      (sym)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_char    <= '0;
         tx_kflag   <= '0;
         tx_invalid <= '0;
      end else begin
         tx_char    <= nxt_char;
         tx_kflag   <= nxt_k;
         tx_invalid <= nxt_bad;
      end
   end

endmodule

// File: rtl/xgx_char_mapper_chk.sv
module xgx_char_mapper_chk #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int A_MIN  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES*BYTE_W-1:0] xg_data,
   input logic [LANES-1:0]        xg_ctl,
   input logic                    col_idle,
   input logic [LANES*BYTE_W-1:0] tx_char,
   input logic [LANES-1:0]        tx_kflag,
   input logic [LANES-1:0]        tx_invalid
);

   logic       live_q;
   logic       idle_q1;
   logic       idle_q2;
   logic       seen_a;
   logic [7:0] gap;
   logic       all_align;
   logic       all_comma;
   logic       all_same;

   always_comb begin
      all_align = 1'b1;
      all_comma = 1'b1;
      all_same  = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         if (tx_char[i*BYTE_W +: BYTE_W] != 8'h7C) all_align = 1'b0;
         if (tx_char[i*BYTE_W +: BYTE_W] != 8'hBC) all_comma = 1'b0;
         if (tx_char[i*BYTE_W +: BYTE_W] != tx_char[BYTE_W-1:0]) all_same = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= 1'b0;
         idle_q1 <= 1'b0;
         idle_q2 <= 1'b0;
         seen_a  <= 1'b0;
         gap     <= '0;
      end else begin
         live_q  <= 1'b1;
         idle_q1 <= col_idle;
         idle_q2 <= idle_q1;
         if (idle_q1 && all_align) begin
            seen_a <= 1'b1;
            gap    <= 8'd1;
         end else if (gap != 8'hFF) begin
            gap    <= gap + 8'd1;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
         live_q && $past(!xg_ctl[i]) |->
            !tx_kflag[i] && tx_char[i*BYTE_W +: BYTE_W] == $past(xg_data[i*BYTE_W +: BYTE_W]));

      assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
         live_q && $past(xg_ctl[i] && xg_data[i*BYTE_W +: BYTE_W] == 8'hFB) |->
            tx_kflag[i] && tx_char[i*BYTE_W +: BYTE_W] == 8'hFB);

      assert_invalid_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
         tx_invalid[i] |-> tx_kflag[i] && tx_char[i*BYTE_W +: BYTE_W] == 8'hFE);
   end

   assert_idle_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q1 |-> all_same && (&tx_kflag) && tx_invalid == '0);

   assert_first_comma_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q1 && !idle_q2 |-> all_comma);

   assert_align_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q1 && all_align && seen_a |-> gap >= 8'(A_MIN));

endmodule

bind xgx_char_mapper xgx_char_mapper_chk #(
   .LANES  (LANES),
   .BYTE_W (BYTE_W),
   .A_MIN  (A_MIN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xg_data    (xg_data),
   .xg_ctl     (xg_ctl),
   .col_idle   (col_idle),
   .tx_char    (tx_char),
   .tx_kflag   (tx_kflag),
   .tx_invalid (tx_invalid)
);

// File: tb/sim_xgx_char_mapper.sv
module sim_xgx_char_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int NL         = 4;
   localparam int WATCHDOG   = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_trans_en = 1'b1;
   logic          cfg_akr_en = 1'b0;
   logic          cfg_xaui_en = 1'b0;
   logic          idle_wr = 1'b0;
   logic [7:0]    idle_wr_data = 8'h00;
   logic [31:0]   xg_data = '0;
   logic [3:0]    xg_ctl = '0;
   logic [31:0]   tx_char;
   logic [3:0]    tx_kflag;
   logic [3:0]    tx_invalid;

   int n_vec = 0;
   int n_bad = 0;
   int n_align_cols = 0;

   // reference model state
   logic [6:0] m_prbs;
   int         m_cnt;
   bit         m_prev;
   logic [7:0] m_idle;
   logic [7:0] e_char [NL];
   bit         e_k    [NL];
   bit         e_inv  [NL];
   string      e_req  [NL];
   bit         e_idlecol;

   always #(CLK_PERIOD/2) clk = ~clk;

   xgx_char_mapper u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_trans_en (cfg_trans_en),
      .cfg_akr_en   (cfg_akr_en),
      .cfg_xaui_en  (cfg_xaui_en),
      .idle_wr      (idle_wr),
      .idle_wr_data (idle_wr_data),
      .xg_data      (xg_data),
      .xg_ctl       (xg_ctl),
      .tx_char      (tx_char),
      .tx_kflag     (tx_kflag),
      .tx_invalid   (tx_invalid)
   );

   function automatic bit reserved(input logic [7:0] b);
      return b == 8'hBC || b == 8'h7C || b == 8'h1C || b == 8'hFB;
   endfunction

   // idle-class test per lane in the model (R9)
   function automatic bit lane_idleish(input bit k, input logic [7:0] b, input logic [7:0] ic, input bit te);
      if (!k) return 0;
      if (b == 8'hBC || b == 8'h7C || b == 8'h1C) return 1;
      return (b == ic) && te && (b != 8'hFB);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prbs = 7'h7F; m_cnt = 0; m_prev = 0; m_idle = 8'h07; e_idlecol = 0;   // R1, R12
         for (int i = 0; i < NL; i++) begin
            e_char[i] = 8'h00; e_k[i] = 0; e_inv[i] = 0; e_req[i] = "R1";
         end
      end else begin
         bit rnd;
         bit allidle;
         logic [7:0] s;
         bit is_a;
         rnd = cfg_xaui_en || (cfg_trans_en && cfg_akr_en);           // R8
         allidle = rnd;
         for (int i = 0; i < NL; i++)
            if (!lane_idleish(xg_ctl[i], xg_data[i*8 +: 8], m_idle, cfg_trans_en)) allidle = 0;
         is_a = 0;
         if (!m_prev)            s = 8'hBC;                            // R10
         else if (m_cnt == 0) begin s = 8'h7C; is_a = 1; end           // R11
         else if (m_prbs[6])     s = 8'h1C;                            // R12
         else                    s = 8'hBC;
         e_idlecol = allidle;
         for (int i = 0; i < NL; i++) begin
            logic [7:0] b;
            b = xg_data[i*8 +: 8];
            e_inv[i] = 0; e_k[i] = 1;
            if (allidle) begin
               e_char[i] = s;
               e_req[i] = !m_prev ? "R10" : (is_a ? "R11" : "R12");
            end else if (!xg_ctl[i]) begin
               e_char[i] = b; e_k[i] = 0; e_req[i] = "R2";
            end else if (b == 8'hFB) begin
               e_char[i] = 8'hFB; e_req[i] = "R3";
            end else if (b == 8'hBC || b == 8'h7C || b == 8'h1C) begin
               e_char[i] = b; e_req[i] = rnd ? "R9" : "R4";
            end else if (b == m_idle) begin
               if (cfg_trans_en) begin e_char[i] = 8'hBC; e_req[i] = rnd ? "R9" : "R7"; end
               else begin e_char[i] = 8'hFE; e_inv[i] = 1; e_req[i] = "R5"; end
            end else begin
               e_char[i] = b; e_req[i] = "R6";
            end
         end
         if (allidle && is_a) m_cnt = 15 + int'(m_prbs[3:0]);
         else if (m_cnt != 0) m_cnt = m_cnt - 1;
         m_prev = allidle;
         m_prbs = {m_prbs[5:0], m_prbs[6] ^ m_prbs[5]};
         if (idle_wr && !reserved(idle_wr_data)) m_idle = idle_wr_data;  // R7
      end
   end

   task automatic compare();
      bit acol;
      acol = e_idlecol;
      for (int i = 0; i < NL; i++) begin
         n_vec++;
         if (tx_char[i*8 +: 8] !== e_char[i] || tx_kflag[i] !== e_k[i] || tx_invalid[i] !== e_inv[i]) begin
            n_bad++;
            $display("FAIL %s lane %0d: got char=%02h k=%0b inv=%0b, expected char=%02h k=%0b inv=%0b",
                     e_req[i], i, tx_char[i*8 +: 8], tx_kflag[i], tx_invalid[i], e_char[i], e_k[i], e_inv[i]);
         end
         if (e_char[i] != 8'h7C) acol = 0;
      end
      if (acol) n_align_cols++;
   endtask

   function automatic logic [8:0] pick_lane(input int mode, input logic [7:0] ic);
      int r;
      r = int'($urandom_range(0, 9));
      if (mode == 1) begin   // idle-class only
         case (r % 4)
            0: return {1'b1, ic};
            1: return {1'b1, 8'hBC};
            2: return {1'b1, 8'h7C};
            default: return {1'b1, 8'h1C};
         endcase
      end
      case (r)
         0, 1, 2: return {1'b0, 8'($urandom)};
         3: return {1'b1, 8'hFB};
         4: return {1'b1, 8'hBC};
         5: return {1'b1, 8'h7C};
         6: return {1'b1, 8'h1C};
         7: return {1'b1, ic};
         8: return {1'b1, 8'hFD};
         default: return {1'b1, 8'h9C};
      endcase
   endfunction

   task automatic run_cols(input int n, input int idle_pct, input logic [7:0] ic);
      for (int c = 0; c < n; c++) begin
         int md;
         @(negedge clk);
         compare();
         idle_wr = 1'b0;
         md = (int'($urandom_range(0, 99)) < idle_pct) ? 1 : 0;
         for (int i = 0; i < NL; i++) begin
            logic [8:0] v;
            v = pick_lane(md, ic);
            xg_ctl[i] = v[8];
            xg_data[i*8 +: 8] = v[7:0];
         end
      end
   endtask

   task automatic write_idle(input logic [7:0] v);
      @(negedge clk);
      compare();
      idle_wr = 1'b1;
      idle_wr_data = v;
      xg_ctl = '0;
      xg_data = 32'h0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compare();
      rst_n = 1'b1;
      // R2 R3 R4 R6: fixed mode with default idle 0x07
      cfg_trans_en = 1; cfg_akr_en = 0; cfg_xaui_en = 0;
      run_cols(200, 0, 8'h07);
      // R5: idle code while translate disabled
      cfg_trans_en = 0;
      run_cols(100, 30, 8'h07);
      // R8: AKR enable alone does not randomize
      cfg_akr_en = 1;
      run_cols(100, 80, 8'h07);
      // R7: legal write, then reserved writes ignored
      cfg_trans_en = 1; cfg_akr_en = 0;
      write_idle(8'h55);
      run_cols(60, 40, 8'h55);
      write_idle(8'hBC);
      run_cols(40, 40, 8'h55);
      write_idle(8'hFB);
      run_cols(40, 40, 8'h55);
      run_cols(20, 40, 8'h07);
      // R8 R9 R10 R11 R12: randomized via XAUI enable
      cfg_xaui_en = 1;
      run_cols(1500, 100, 8'h55);
      run_cols(1500, 90, 8'h55);
      // randomized via translate + AKR
      cfg_xaui_en = 0; cfg_akr_en = 1;
      run_cols(1500, 92, 8'h55);
      // translate off while XAUI enable: idle code invalid, others still idle
      cfg_trans_en = 0; cfg_xaui_en = 1;
      run_cols(300, 90, 8'h55);
      @(negedge clk);
      compare();
      // R11: alignment columns must have appeared
      n_vec++;
      if (n_align_cols == 0) begin
         n_bad++;
         $display("FAIL R11: got %0d alignment columns, expected more than 0", n_align_cols);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule